// File: doc/BRIEF.md
# Write-Protect Register Controller

This block keeps the protection state of a byte-wide serial memory and judges every write request the serial front end presents. The state has two parts. Two volatile enable latches are cleared by the soft power-up reset. Three retained bits are not: a hardware-protect enable and a two-bit lock field. These retained bits power up as zero, which is the erased state, and survive any later soft reset. Together with the program-protect pin, this state decides whether a write is acknowledged. It also decides whether a write lands in the protect register or in the array.

A request carries a target address, a data byte and a flag. The flag is set when the write is a lone byte, as opposed to part of a multi-byte sector burst. A lone byte sent to the highest address goes to the protect register. There it is decoded as a command that sets or clears the latches, or that programs the retained bits. Every other write goes to the array. An array write is gated by the enable latch and by the locked region. Both decisions are combinational, so they are ready in the cycle of the request. The register update takes effect on the following clock edge. The current register image is always present on a read port.

Top module: `wp_guard`

## Requirements
- R1: The soft reset (`rst_n` low) clears both enable latches. It leaves the protect-enable bit and the lock field unchanged. Before any program command, the retained bits read as zero.
- R2: `wr_reg` is 1 only for a valid request with `req_single`=1 to the highest address. A request to the highest address with `req_single`=0 is an array write and is subject to the array rules.
- R3: An array write is refused (`wr_ok`=0) while the write-enable latch is 0.
- R4: An accepted register write of 0x00 clears both enable latches. An accepted register write of 0x02 or 0x03 sets the write-enable latch when the register-enable latch is 0.
- R5: An accepted register write of 0x06 or 0x07 sets the register-enable latch only if the write-enable latch is already 1. Otherwise it has no effect. The register-enable latch is never 1 while the write-enable latch is 0.
- R6: While the register-enable latch is 1, an accepted register write whose bits 6:5 are 00 and whose bits 2:0 are 010 does two things. It copies bit 7 into the protect-enable bit and bits 4:3 into the lock field, and it clears the register-enable latch.
- R7: While the register-enable latch is 1, a register write whose bits 6:5 are 00 and whose bits 2:0 are 110 is acknowledged. It leaves the retained bits unchanged and the register-enable latch set.
- R8: The lock field selects the refused array region. 00 locks nothing. 01 locks addresses whose two top bits are 11. 10 locks addresses whose top bit is 1. 11 locks every array address. Register writes are never refused by the lock.
- R9: While `pp_pin`=1 and the protect-enable bit is 1, every register write is refused and the retained bits cannot change. Array writes follow R3 and R8.
- R10: `prot_q` shows the protect-enable bit at bit 7, the lock field at bits 4:3, the register-enable latch at bit 2 and the write-enable latch at bit 1. All other bits are 0.
- R11: A refused request, an idle cycle, and a register write that matches none of the commands all leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft power-up reset, active low, clears volatile latches only |
| req_valid | input | 1 | A write request is present this cycle |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Data byte of the write |
| req_single | input | 1 | 1 when the write is a lone byte, 0 inside a sector burst |
| pp_pin | input | 1 | Program-protect pin |
| wr_ok | output | 1 | Write may be acknowledged and committed |
| wr_reg | output | 1 | Write targets the protect register instead of the array |
| prot_q | output | 8 | Current protect register image |

## Verification
The assertions assume that `req_valid`, `req_addr`, `req_data`, `req_single` and `pp_pin` change only away from the rising edge. They also assume these inputs are stable across the edge where a decision is taken. The assertions also rely on the retained bits starting from the erased value. The bench drives every input on the falling edge and holds it through the next rising edge. The pin is toggled only between requests. After directed unlock, program and lock sequences, a seeded random phase mixes command codes with arbitrary bytes, addresses and pin levels.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_single,
  input  logic              pp_pin,
  output logic              wr_ok,
  output logic              wr_reg,
  output logic [7:0]        prot_q
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic       wel_q, rwel_q;
  logic       ppen_q = 1'b0;
  logic [1:0] lock_q = 2'b00;

  logic hw_prot, in_lock, commit;
  logic cmd_clear, cmd_prog, cmd_wel, cmd_rwel;

  assign hw_prot = pp_pin & ppen_q;
  assign wr_reg  = req_valid & req_single & (req_addr == TOP_ADDR);

  always_comb begin
    case (lock_q)
      2'b01:   in_lock = &req_addr[ADDR_W-1 -: 2];
      2'b10:   in_lock = req_addr[ADDR_W-1];
      2'b11:   in_lock = 1'b1;
      default: in_lock = 1'b0;
    endcase
  end

  assign wr_ok  = req_valid & (wr_reg ? ~hw_prot : (wel_q & ~in_lock));
  assign commit = wr_ok & wr_reg;

  assign cmd_clear = (req_data == 8'h00);
  assign cmd_prog  = rwel_q & (req_data[6:5] == 2'b00) & (req_data[2:0] == 3'b010);
  assign cmd_wel   = (req_data[7:1] == 7'b0000001);
  assign cmd_rwel  = (req_data[7:1] == 7'b0000011) & wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (commit) begin
      if (cmd_clear) begin
        wel_q  <= 1'b0;
        rwel_q <= 1'b0;
      end else if (cmd_prog) begin
        rwel_q <= 1'b0;
      end else if (cmd_wel) begin
        wel_q <= 1'b1;
      end else if (cmd_rwel) begin
        rwel_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && commit && !cmd_clear && cmd_prog) begin
      ppen_q <= req_data[7];
      lock_q <= req_data[4:3];
    end
  end

  assign prot_q = {ppen_q, 2'b00, lock_q, rwel_q, wel_q, 1'b0};

  assert_rwel_implies_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_q |-> wel_q);

  assert_rwel_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel_q) |-> $past(wel_q));

  assert_frozen_under_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_pin && ppen_q) |=> $stable({ppen_q, lock_q}));

  assert_prog_consumes_rwel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ppen_q, lock_q}) |-> ($past(rwel_q) && !rwel_q));

  assert_locked_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wr_reg && lock_q == 2'b11) |-> !wr_ok);

  assert_reg_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reg |-> (req_single && req_valid));
endmodule

// File: tb/wp_guard_tb_top.sv
`timescale 1ns/1ps
module wp_guard_tb_top;
  localparam int AW = 13;
  localparam logic [AW-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, s = 1'b0, pp = 1'b0;
  logic [AW-1:0] a = '0;
  logic [7:0] d = '0;
  logic ok, rg;
  logic [7:0] pq;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_wel = 0, m_rwel = 0, m_ppen = 0;
  bit [1:0] m_bl = 0;

  always #2.5 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_addr(a), .req_data(d),
    .req_single(s), .pp_pin(pp), .wr_ok(ok), .wr_reg(rg), .prot_q(pq)
  );

  function automatic bit locked(input bit [AW-1:0] ad);
    if (m_bl == 2'b01) return ad >= (TOP - (TOP >> 2));
    if (m_bl == 2'b10) return ad >= (TOP - (TOP >> 1));
    if (m_bl == 2'b11) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit vv, input bit [AW-1:0] aa, input bit [7:0] dd,
                      input bit ss, input bit pv, input string tag);
    bit isreg, eok;
    v = vv; a = aa; d = dd; s = ss; pp = pv;
    #1;
    isreg = vv && ss && (aa == TOP);
    if (!vv) eok = 0;
    else if (isreg) eok = !(pv && m_ppen);
    else eok = m_wel && !locked(aa);
    chk(tag, "wr_ok", ok, eok);
    chk(tag, "wr_reg", rg, isreg);
    chk("R10", "prot_q", pq, {m_ppen, 2'b00, m_bl, m_rwel, m_wel, 1'b0});
    @(posedge clk);
    if (eok && isreg) begin
      if (dd == 8'h00) begin m_wel = 0; m_rwel = 0; end
      else if (m_rwel && dd[6:5] == 0 && dd[2:0] == 3'b010) begin
        m_ppen = dd[7]; m_bl = dd[4:3]; m_rwel = 0;
      end else if (dd[7:1] == 7'b0000001) m_wel = 1;
      else if (dd[7:1] == 7'b0000011 && m_wel) m_rwel = 1;
    end
    @(negedge clk);
    v = 0;
  endtask

  task automatic soft_reset();
    rst_n = 0; #1; m_wel = 0; m_rwel = 0;
    @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", "reset prot_q", pq, 8'h00);
    rst_n = 1; @(negedge clk);
    step(0, 5, 8'h55, 1, 0, "R11");
    step(1, 5, 8'h55, 1, 0, "R3");
    step(1, TOP, 8'h02, 0, 0, "R2");
    step(1, TOP, 8'h06, 1, 0, "R5");
    step(1, TOP, 8'h02, 1, 0, "R4");
    step(1, 5, 8'h55, 1, 0, "R3");
    step(1, TOP, 8'h00, 1, 0, "R4");
    step(1, TOP, 8'h03, 1, 0, "R4");
    step(1, TOP, 8'h07, 1, 0, "R5");
    step(1, TOP, 8'h9E, 1, 0, "R7");
    step(1, TOP, 8'h55, 1, 0, "R11");
    step(1, TOP, 8'h0A, 1, 0, "R6");
    step(1, TOP, 8'h0A, 1, 0, "R11");
    step(1, TOP - 1, 8'h11, 0, 0, "R8");
    step(1, TOP, 8'h11, 0, 0, "R8");
    step(1, 13'h17FF, 8'h11, 0, 0, "R8");
    step(1, TOP, 8'h06, 1, 0, "R5");
    step(1, TOP, 8'h12, 1, 0, "R6");
    step(1, 13'h1000, 8'h11, 0, 0, "R8");
    step(1, 13'h0FFF, 8'h11, 0, 0, "R8");
    step(1, TOP, 8'h06, 1, 0, "R5");
    step(1, TOP, 8'h1A, 1, 0, "R6");
    step(1, 13'h0000, 8'h11, 0, 0, "R8");
    step(1, TOP, 8'h02, 1, 0, "R8");
    step(1, TOP, 8'h06, 1, 0, "R5");
    step(1, TOP, 8'h9A, 1, 0, "R6");
    step(1, TOP, 8'h00, 1, 1, "R9");
    step(1, TOP, 8'h06, 1, 1, "R9");
    step(1, 13'h0010, 8'h00, 0, 1, "R9");
    soft_reset();
    chk("R1", "soft reset keeps retained", pq, 8'h98);
    step(1, TOP, 8'h02, 1, 1, "R9");
    step(1, TOP, 8'h02, 1, 0, "R9");
    step(1, TOP, 8'h06, 1, 0, "R5");
    step(1, TOP, 8'h82, 1, 0, "R6");
    step(1, 13'h1FF0, 8'h00, 0, 1, "R9");
    step(1, TOP, 8'h00, 1, 0, "R4");
    for (int i = 0; i < 400; i++) begin
      bit [7:0] dd;
      bit [AW-1:0] aa;
      int k = $urandom_range(0, 9);
      case (k)
        0: dd = 8'h00;
        1: dd = 8'h02;
        2: dd = 8'h03;
        3: dd = 8'h06;
        4: dd = {$urandom_range(0, 1) == 1, 2'b00, 2'($urandom_range(0, 3)), 3'b010};
        5: dd = {$urandom_range(0, 1) == 1, 2'b00, 2'($urandom_range(0, 3)), 3'b110};
        default: dd = 8'($urandom);
      endcase
      aa = ($urandom_range(0, 2) == 0) ? TOP : AW'($urandom);
      if ($urandom_range(0, 40) == 0) soft_reset();
      step($urandom_range(0, 5) != 0, aa, dd, $urandom_range(0, 2) != 0,
           $urandom_range(0, 3) == 0, "R11");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule